// File: doc/BRIEF.md
# CPU Address Window Decoder

This block sits between a CPU master port and a set of slave targets. It holds eight address windows, each programmed through a 32-bit configuration port. Every incoming 32-bit address is compared against all enabled windows. When the address lands in one, the block returns that window's number, its 4-bit target ID, its 8-bit attribute byte and a translated address. When no window claims the address, it raises a miss flag.

Windows start on 64 KiB boundaries and span a power-of-two number of 64 KiB pages. Only the lowest-numbered windows, up to a parameter `REMAP_WIN`, can redirect the upper address bits to another region. All other windows pass the address through unchanged. When several windows overlap, the lowest-numbered one decides the result, and an overlap flag reports the conflict.

Lookups move as a stream. A request is accepted on `req_valid && req_ready`. The result is registered and appears on `rsp_*` one cycle after acceptance. If the consumer holds `rsp_ready` low while a result is waiting, the result stays frozen and `req_ready` drops, so back-pressure reaches the requester with no added latency. A new request can be accepted in the same cycle that the waiting result is taken. The configuration port is a plain register interface. Writes take effect on the clock edge, and reads are combinational.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, all window registers read as zero, no window is enabled, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Configuration byte offset = window*0x10 + register. The registers are 0x0 control, 0x4 base, 0x8 remap-low and 0xC remap-high. Control keeps bits [31:16] size-1 (in 64 KiB pages), [15:8] attribute, [7:4] target and [0] enable, so it reads back under mask 0xFFFFFFF1. Base and remap-low keep only bits [31:16]. Remap-high keeps all 32 bits but has no effect on decode.
- R3: For windows at or above `REMAP_WIN`, remap-low and remap-high read as zero, and writes to them are ignored.
- R4: A window hits when its enable bit is 1 and ((addr[31:16] ^ base[31:16]) & ~size_field) == 0.
- R5: When no window hits, the response has `rsp_miss`=1 and `rsp_hit`=0. `rsp_win`, `rsp_target` and `rsp_attr` are 0, and `rsp_addr` equals the request address.
- R6: When several windows hit, the lowest-numbered one supplies window, target, attribute and address, and `rsp_multi`=1. With a single hit, `rsp_multi`=0.
- R7: On a hit in a window below `REMAP_WIN`, rsp_addr = {(remap_lo & ~size_field) | (addr[31:16] & size_field), addr[15:0]}.
- R8: On a hit in a window at or above `REMAP_WIN`, `rsp_addr` equals the request address.
- R9: The result of an accepted request appears with `rsp_valid`=1 at the next clock edge. While `rsp_valid`=1 and `rsp_ready`=0, every `rsp_*` output holds its value.
- R10: `req_ready` is 0 exactly when a result is waiting (`rsp_valid`=1) and `rsp_ready`=0.
- R11: A window whose enable bit is 0 never hits, even if its base would match. Writing zero to control and base turns a window off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NUM_WIN)+4 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | 32 | Address to decode |
| rsp_valid | output | 1 | Decode result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Some window claimed the address |
| rsp_miss | output | 1 | No window claimed the address |
| rsp_multi | output | 1 | More than one window claimed the address |
| rsp_win | output | $clog2(NUM_WIN) | Number of the winning window |
| rsp_target | output | 4 | Target ID of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |
| rsp_addr | output | 32 | Translated address |

## Verification
The bench sweeps the upper 16 bits of the address over 256 consecutive page numbers, with a scrambled lower half. The map used for the sweep contains:
- a remapped window with a remap value that has bits inside its size, which shows whether those bits are masked;
- a single-page window;
- two overlap pairs, one remappable and one not, which test priority and the overlap flag;
- a disabled window with a matching base.

The sweep is run a second time after one window is cleared by writing zeros. This shows that the decode follows the registers rather than stale state. An all-ones write to every register checks field masks and the missing remap registers. A stalled-response sequence separates the hold rule from the ready rule.

// File: rtl/awd_pkg.sv
package awd_pkg;

  // Fields kept from a window control word
  typedef struct packed {
    logic [15:0] size;    // page count minus one, 64 KiB pages
    logic [7:0]  attr;
    logic [3:0]  target;
    logic        en;
  } awd_ctl_t;

  // Register slot inside one window's 16-byte group
  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_BASE = 2'd1,
    REG_RLO  = 2'd2,
    REG_RHI  = 2'd3
  } awd_reg_e;

  function automatic logic [31:0] ctl_pack(input awd_ctl_t c);
    return {c.size, c.attr, c.target, 3'b000, c.en};
  endfunction

  function automatic awd_ctl_t ctl_unpack(input logic [31:0] w);
    awd_ctl_t c;
    c.size   = w[31:16];
    c.attr   = w[15:8];
    c.target = w[7:4];
    c.en     = w[0];
    return c;
  endfunction

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned REMAP_WIN = 4,
  parameter int unsigned WIN_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [WIN_W+3:0] cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output awd_ctl_t         ctl_o  [NUM_WIN],
  output logic [15:0]      base_o [NUM_WIN],
  output logic [15:0]      rlo_o  [NUM_WIN]
);

  logic [WIN_W-1:0] sel_win;
  awd_reg_e         sel_reg;
  logic             sel_ok;
  logic [31:0]      rhi_w [NUM_WIN];
  logic             unused_bits;

  assign sel_win     = cfg_addr[WIN_W+3:4];
  assign sel_reg     = awd_reg_e'(cfg_addr[3:2]);
  assign sel_ok      = (32'(sel_win) < NUM_WIN);
  assign unused_bits = ^{cfg_addr[1:0], cfg_wdata[3:1]};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic        wr_sel;
    awd_ctl_t    ctl_q;
    logic [15:0] base_q;

    assign wr_sel = cfg_we && sel_ok && (sel_win == WIN_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q  <= '0;
        base_q <= '0;
      end else if (wr_sel) begin
        if (sel_reg == REG_CTL)  ctl_q  <= ctl_unpack(cfg_wdata);
        if (sel_reg == REG_BASE) base_q <= cfg_wdata[31:16];
      end
    end

    assign ctl_o[w]  = ctl_q;
    assign base_o[w] = base_q;

    if (w < REMAP_WIN) begin : g_remap
      logic [15:0] rlo_q;
      logic [31:0] rhi_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rlo_q <= '0;
          rhi_q <= '0;
        end else if (wr_sel) begin
          if (sel_reg == REG_RLO) rlo_q <= cfg_wdata[31:16];
          if (sel_reg == REG_RHI) rhi_q <= cfg_wdata;
        end
      end
      assign rlo_o[w] = rlo_q;
      assign rhi_w[w] = rhi_q;
    end else begin : g_plain
      assign rlo_o[w] = '0;
      assign rhi_w[w] = '0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (sel_ok) begin
      unique case (sel_reg)
        REG_CTL:  cfg_rdata = ctl_pack(ctl_o[sel_win]);
        REG_BASE: cfg_rdata = {base_o[sel_win], 16'h0000};
        REG_RLO:  cfg_rdata = {rlo_o[sel_win], 16'h0000};
        REG_RHI:  cfg_rdata = rhi_w[sel_win];
        default:  cfg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/awd_match.sv
module awd_match
  import awd_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8
) (
  input  logic [15:0]        page_i,
  input  awd_ctl_t           ctl_i  [NUM_WIN],
  input  logic [15:0]        base_i [NUM_WIN],
  output logic [NUM_WIN-1:0] hit_o
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [15:0] diff;
    assign diff     = (page_i ^ base_i[w]) & ~ctl_i[w].size;
    assign hit_o[w] = ctl_i[w].en && (diff == 16'h0000);
  end

endmodule

// File: rtl/awd_select.sv
module awd_select
  import awd_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned REMAP_WIN = 4,
  parameter int unsigned WIN_W     = 3
) (
  input  logic [31:0]        addr_i,
  input  logic [NUM_WIN-1:0] hit_i,
  input  awd_ctl_t           ctl_i [NUM_WIN],
  input  logic [15:0]        rlo_i [NUM_WIN],
  output logic               any_o,
  output logic               multi_o,
  output logic [WIN_W-1:0]   win_o,
  output logic [3:0]         target_o,
  output logic [7:0]         attr_o,
  output logic [31:0]        addr_o
);

  logic [15:0] mask;
  logic [15:0] new_page;

  always_comb begin
    win_o = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_i[w]) win_o = WIN_W'(w);
    end
  end

  assign any_o   = |hit_i;
  assign multi_o = ($countones(hit_i) > 1);
  assign mask    = ctl_i[win_o].size;
  assign new_page = (rlo_i[win_o] & ~mask) | (addr_i[31:16] & mask);

  always_comb begin
    target_o = '0;
    attr_o   = '0;
    addr_o   = addr_i;
    if (any_o) begin
      target_o = ctl_i[win_o].target;
      attr_o   = ctl_i[win_o].attr;
      if (32'(win_o) < REMAP_WIN) addr_o = {new_page, addr_i[15:0]};
    end
  end

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned REMAP_WIN = 4,
  localparam int unsigned WIN_W    = $clog2(NUM_WIN),
  localparam int unsigned CFG_AW   = WIN_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_multi,
  output logic [WIN_W-1:0]  rsp_win,
  output logic [3:0]        rsp_target,
  output logic [7:0]        rsp_attr,
  output logic [31:0]       rsp_addr
);

  awd_ctl_t           ctl  [NUM_WIN];
  logic [15:0]        base [NUM_WIN];
  logic [15:0]        rlo  [NUM_WIN];
  logic [NUM_WIN-1:0] hit;
  logic               d_any, d_multi;
  logic [WIN_W-1:0]   d_win;
  logic [3:0]         d_target;
  logic [7:0]         d_attr;
  logic [31:0]        d_addr;
  logic               take;

  awd_regfile #(.NUM_WIN(NUM_WIN), .REMAP_WIN(REMAP_WIN), .WIN_W(WIN_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ctl_o(ctl), .base_o(base), .rlo_o(rlo)
  );

  awd_match #(.NUM_WIN(NUM_WIN)) match_i (
    .page_i(req_addr[31:16]), .ctl_i(ctl), .base_i(base), .hit_o(hit)
  );

  awd_select #(.NUM_WIN(NUM_WIN), .REMAP_WIN(REMAP_WIN), .WIN_W(WIN_W)) sel_i (
    .addr_i(req_addr), .hit_i(hit), .ctl_i(ctl), .rlo_i(rlo),
    .any_o(d_any), .multi_o(d_multi), .win_o(d_win),
    .target_o(d_target), .attr_o(d_attr), .addr_o(d_addr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (take) begin
      rsp_valid <= 1'b1;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_multi  <= 1'b0;
      rsp_win    <= '0;
      rsp_target <= '0;
      rsp_attr   <= '0;
      rsp_addr   <= '0;
    end else if (take) begin
      rsp_hit    <= d_any;
      rsp_miss   <= !d_any;
      rsp_multi  <= d_multi;
      rsp_win    <= d_win;
      rsp_target <= d_target;
      rsp_attr   <= d_attr;
      rsp_addr   <= d_addr;
    end
  end

endmodule

// File: rtl/awd_chk.sv
module awd_chk #(
  parameter int unsigned WIN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_multi,
  input logic [WIN_W-1:0] rsp_win,
  input logic [3:0]       rsp_target,
  input logic [7:0]       rsp_attr,
  input logic [31:0]      rsp_addr
);

  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_win)
      && $stable(rsp_target) && $stable(rsp_attr) && $stable(rsp_hit)));

  // R10
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R5
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss}));

  // R5
  miss_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_target == 4'h0 && rsp_attr == 8'h00 && rsp_win == '0));

  // R6
  multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_multi) |-> rsp_hit);

endmodule

bind addr_window_decoder awd_chk #(.WIN_W(WIN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss), .rsp_multi(rsp_multi), .rsp_win(rsp_win),
  .rsp_target(rsp_target), .rsp_attr(rsp_attr), .rsp_addr(rsp_addr)
);

// File: tb/addr_window_decoder_tb_top.sv
module addr_window_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_miss, rsp_multi;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_target;
  logic [7:0]  rsp_attr;
  logic [31:0] rsp_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [31:0] m_ctl  [NW];
  logic [15:0] m_base [NW];
  logic [15:0] m_rlo  [NW];

  logic        e_hit, e_multi;
  logic [2:0]  e_win;
  logic [3:0]  e_tgt;
  logic [7:0]  e_attr;
  logic [31:0] e_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_decoder #(.NUM_WIN(NW), .REMAP_WIN(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_multi(rsp_multi), .rsp_win(rsp_win),
    .rsp_target(rsp_target), .rsp_attr(rsp_attr), .rsp_addr(rsp_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int w, input int r, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(w * 16 + r * 4); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input int w, input int r, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 7'(w * 16 + r * 4);
    #1 d = cfg_rdata;
  endtask

  // program one window in the DUT and in the bench model
  task automatic set_win(input int w, input logic [15:0] size, input logic [7:0] attr,
                         input logic [3:0] tgt, input logic en,
                         input logic [15:0] base, input logic [15:0] rlo);
    m_ctl[w]  = {size, attr, tgt, 3'b000, en};
    m_base[w] = base;
    m_rlo[w]  = (w < NR) ? rlo : 16'h0000;
    cfg_write(w, 0, m_ctl[w] | 32'h0000_000E);   // reserved bits must drop
    cfg_write(w, 1, {base, 16'hABCD});             // low half must drop
    cfg_write(w, 2, {rlo, 16'h1234});
    cfg_write(w, 3, 32'h0);
  endtask

  // expected result from the requirement rules
  task automatic model(input logic [31:0] a);
    int n;
    n = 0; e_hit = 0; e_win = 0; e_tgt = 0; e_attr = 0; e_addr = a;
    for (int w = NW - 1; w >= 0; w--) begin
      if (m_ctl[w][0] && (((a[31:16] ^ m_base[w]) & ~m_ctl[w][31:16]) == 16'h0)) begin
        n++; e_hit = 1; e_win = 3'(w);
      end
    end
    e_multi = (n > 1);
    if (e_hit) begin
      e_tgt  = m_ctl[e_win][7:4];
      e_attr = m_ctl[e_win][15:8];
      if (e_win < NR)
        e_addr = {(m_rlo[e_win] & ~m_ctl[e_win][31:16]) | (a[31:16] & m_ctl[e_win][31:16]), a[15:0]};
    end
  endtask

  task automatic lookup(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic sweep();
    string tag;
    for (int p = 0; p < 256; p++) begin
      logic [31:0] a;
      a = {16'(p), 16'(p * 16'h9E37 + 16'h0123)};
      lookup(a);
      model(a);
      if (!e_hit) tag = (p >= 16'h80 && p <= 16'h8F) ? "R11" : "R5";
      else if (e_multi) tag = "R6";
      else if (e_win < NR) tag = "R7";
      else tag = "R8";
      chk({tag, " status/R4"}, {15'h0, rsp_valid, rsp_hit, rsp_miss, rsp_multi, rsp_win, rsp_tgt_attr()},
          {15'h0, 1'b1, e_hit, !e_hit, e_multi, e_win, e_tgt, e_attr});
      chk({tag, " addr"}, rsp_addr, e_addr);
    end
  endtask

  function automatic logic [11:0] rsp_tgt_attr();
    return {rsp_target, rsp_attr};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] held;
    for (int w = 0; w < NW; w++) begin
      m_ctl[w] = '0; m_base[w] = '0; m_rlo[w] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    #1;
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++) begin
        cfg_read(w, r, d);
        chk("R1 reg zero", d, 32'h0);
      end
    lookup(32'h1234_5678);
    chk("R1 no hit after reset", {31'h0, rsp_miss}, 32'h1);

    // R2 / R3: field masks and missing remap registers
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++) cfg_write(w, r, 32'hFFFF_FFFF);
    for (int w = 0; w < NW; w++) begin
      cfg_read(w, 0, d); chk("R2 ctl mask", d, 32'hFFFF_FFF1);
      cfg_read(w, 1, d); chk("R2 base mask", d, 32'hFFFF_0000);
      cfg_read(w, 2, d); chk(w < NR ? "R2 rlo" : "R3 rlo", d, w < NR ? 32'hFFFF_0000 : 32'h0);
      cfg_read(w, 3, d); chk(w < NR ? "R2 rhi" : "R3 rhi", d, w < NR ? 32'hFFFF_FFFF : 32'h0);
    end
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++) cfg_write(w, r, 32'h0);
    cfg_read(0, 0, d); chk("R11 ctl cleared", d, 32'h0);

    // map: remap masking, single page, two overlap pairs, disabled window
    set_win(0, 16'h000F, 8'h1E, 4'h1, 1'b1, 16'h0010, 16'h0805);
    set_win(1, 16'h0001, 8'h51, 4'h3, 1'b1, 16'h0030, 16'h1233);
    set_win(2, 16'h0003, 8'h59, 4'h4, 1'b1, 16'h0014, 16'h2000);
    set_win(3, 16'h0000, 8'h0F, 4'h2, 1'b1, 16'h00A0, 16'hFFFF);
    set_win(4, 16'h001F, 8'h1D, 4'h1, 1'b1, 16'h0040, 16'h7777);
    set_win(5, 16'h000F, 8'h1B, 4'h5, 1'b1, 16'h0050, 16'h0000);
    set_win(6, 16'h000F, 8'h33, 4'h6, 1'b0, 16'h0080, 16'h0000);
    set_win(7, 16'h003F, 8'h07, 4'h7, 1'b1, 16'h00C0, 16'h0000);
    cfg_read(0, 1, d); chk("R2 base readback", d, 32'h0010_0000);
    cfg_read(4, 2, d); chk("R3 rlo ignored", d, 32'h0);
    sweep();

    // R11: clear window 0 by zero writes, overlap with window 2 becomes single
    cfg_write(0, 0, 32'h0); cfg_write(0, 1, 32'h0);
    m_ctl[0] = '0; m_base[0] = '0;
    sweep();

    // R9 / R10: stall holds the result and blocks new requests
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0031_00AA; rsp_ready = 1'b0;
    @(negedge clk);
    req_addr = 32'h00A0_5555;
    #1;
    chk("R9 valid after accept", {31'h0, rsp_valid}, 32'h1);
    chk("R10 ready low on stall", {31'h0, req_ready}, 32'h0);
    held = rsp_addr;
    chk("R7 stalled addr", held, 32'h1233_00AA);
    @(negedge clk);
    #1;
    chk("R9 held addr", rsp_addr, held);
    chk("R9 held valid", {31'h0, rsp_valid}, 32'h1);
    rsp_ready = 1'b1;
    #1 chk("R10 ready with consumer", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R7 next result", rsp_addr, 32'hFFFF_5555);
    chk("R9 next win", {29'h0, rsp_win}, 32'd3);
    @(negedge clk);
    #1 chk("R9 drained", {31'h0, rsp_valid}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule